// File: doc/BRIEF.md
# Direct-Form-I Filter Engine

This block is a sequential multiply-accumulate engine that runs an FIR filter or a direct-form-I IIR filter out of one 256-word local memory. That memory holds three regions:

- the coefficients;
- a circular history of input samples;
- in IIR mode, a circular history of output samples.

Before a run, the host fills the memory through a plain write port. The host may also preload some input history. It then sets the mode code, tap count, feedback count, gain and preload count, and raises `start`.

On the rising edge of `start` the engine checks the configuration. A configuration it cannot hold is refused: the error flag rises and nothing runs. Once launched, the engine takes one sample for each `in_valid`/`in_ready` handshake. As soon as the history holds a full window of N samples, it spends one cycle per term on the sum of products. The result is scaled by the gain, saturated to 16 bits and offered on `out_valid`/`out_ready`.

In IIR mode each delivered result also goes into the output history and feeds the following outputs. Lowering `start` stops the engine at once, wherever it is.

Top module: `dfi_filter_engine`

## Requirements
- R1: Mode code 8 runs an FIR filter, y[n] = sum over k = 0..N-1 of b_k·x[n-k]. N is `tap_cnt` and b_k is read from memory address k. `fb_cnt` has no effect in this mode.
- R2: Mode code 9 runs a direct-form-I IIR filter with M = `fb_cnt`: y[n] = sum over k = 0..N-1 of b_k·x[n-k] plus sum over k = 1..M of a_k·y[n-k]. b_k sits at address k and a_k at address N+k-1.
- R3: The input history occupies N words from address N+M (M is 0 in FIR mode). `preload_cnt` samples already written there, oldest first from the region start, count as history. A result is computed only on an accepted sample for which preloaded plus accepted samples reach N. Samples before that point produce no output.
- R4: Samples and coefficients are signed Q1.15. Products are summed exactly in a 40-bit accumulator. The output is floor(sum·2^gain / 2^15), with gain taken from `gain` (0..7), saturated to the range -32768..32767.
- R5: A launch is refused, `cfg_err` goes high and `in_ready` stays low in any of these cases: the mode is neither 8 nor 9, N is 0, `preload_cnt` exceeds N, FIR with 2N > 256, or IIR with M outside 1..N-1 or 2N+2M > 256. A later accepted launch clears `cfg_err`.
- R6: With `start` low, `in_ready` and `out_valid` are low from the next cycle on, and any result in progress is dropped. A new rising edge of `start` relaunches the engine with fresh pointers and fill count.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Each result is delivered exactly once, in input order.
- R8: Host writes reach memory only while the engine is not running. While it runs they are dropped.
- R9: In IIR mode each delivered result is written into the output history, which occupies M words from address 2N+M and is preloaded by the host, usually with zeros. This happens in the handshake cycle, before the next sample is accepted, so the next result uses it as y[n-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request; a rising edge launches, low stops |
| func | input | 4 | Mode code: 8 FIR, 9 IIR |
| tap_cnt | input | 8 | Feed-forward tap count N |
| fb_cnt | input | 8 | Feedback tap count M (IIR only) |
| gain | input | 3 | Left shift applied before saturation |
| preload_cnt | input | 8 | Input samples already present in the history |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 16 | Host write data |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample, Q1.15 |
| in_ready | output | 1 | Engine can take a sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result, Q1.15 |
| cfg_err | output | 1 | Last launch was refused |

## Verification
The circular pointers are the most likely source of hidden state errors, so the bench uses fixed memory addresses in every check. A wrong newest-sample or newest-output pointer pairs a coefficient with the wrong delayed term. That shows as a wrong `out_data` on the first result after the pointer goes astray, or for feedback errors on the first result that uses the stale history word. A wrong fill count shows as a result appearing one sample too early or too late. Each case is caught at the next output handshake. An accumulator that is not cleared, or a gain applied at the wrong point, corrupts every result from the first one on. A mode or abort fault shows within a cycle as `in_ready` or `out_valid` at the wrong level.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
    localparam int DW    = 16;
    localparam int ACCW  = 40;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW;
    localparam int GW    = 3;
    localparam int FW    = 4;
    localparam int XW    = ACCW + (1 << GW);

    localparam logic [FW-1:0] FN_FIR = FW'(8);
    localparam logic [FW-1:0] FN_IIR = FW'(9);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MAC, ST_OUT} eng_state_e;

    typedef struct packed {
        logic            iir;
        logic [CW-1:0]   n;
        logic [CW-1:0]   m;
        logic [GW-1:0]   gain;
    } eng_cfg_t;

    function automatic logic cfg_fits(input logic [FW-1:0] fn, input logic [CW-1:0] p,
                                      input logic [CW-1:0] q, input logic [CW-1:0] pre);
        int n, m, k;
        n = int'(p);
        m = int'(q);
        k = int'(pre);
        if (n == 0 || k > n) return 1'b0;
        if (fn == FN_FIR) return (2 * n <= DEPTH);
        if (fn == FN_IIR) return (m >= 1 && m < n && 2 * n + 2 * m <= DEPTH);
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] scale_sat(input logic signed [ACCW-1:0] acc,
                                                input logic [GW-1:0] g);
        logic signed [XW-1:0] ext, hi, lo;
        ext = {{(XW-ACCW){acc[ACCW-1]}}, acc};
        ext = ext <<< g;
        ext = ext >>> (DW - 1);
        hi  = XW'((1 << (DW - 1)) - 1);
        lo  = ~hi;
        if (ext > hi) return hi[DW-1:0];
        if (ext < lo) return lo[DW-1:0];
        return ext[DW-1:0];
    endfunction
endpackage

// File: rtl/dfi_mem.sv
module dfi_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/dfi_mac.sv
module dfi_mac
    import dfi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] coef,
    input  logic [DW-1:0] data,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] result
);
    logic signed [ACCW-1:0] acc;
    logic signed [2*DW-1:0] prod;

    assign prod = $signed(coef) * $signed(data);

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= acc + {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
    end

    assign result = scale_sat(acc, gain);

    AST_CLR_NOT_DURING_SUM: assert property (@(posedge clk) disable iff (rst) en |-> !clr); // R3
endmodule

// File: rtl/dfi_ctrl.sv
module dfi_ctrl
    import dfi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] func,
    input  logic [CW-1:0] p_cnt,
    input  logic [CW-1:0] q_cnt,
    input  logic [GW-1:0] gain,
    input  logic [CW-1:0] pre_cnt,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    input  logic [DW-1:0] result,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] c_addr,
    output logic [AW-1:0] d_addr,
    output logic          acc_clr,
    output logic          mac_en,
    output logic [GW-1:0] gain_q,
    output logic          cfg_err
);
    localparam logic [CW-1:0] ONE = CW'(1);

    eng_state_e    st;
    eng_cfg_t      cfg;
    logic          start_q, start_rise, take, last;
    logic [CW-1:0] wx, xn, wy, yn, fill, idx;
    logic [CW-1:0] wx_nx, wy_nx, fill_nx, xbase, ybase, len, off, j;

    assign start_rise = start & ~start_q;
    assign xbase      = cfg.n + cfg.m;
    assign ybase      = xbase + cfg.n;
    assign len        = xbase;
    assign wx_nx      = (wx + ONE == cfg.n) ? '0 : wx + ONE;
    assign wy_nx      = (wy + ONE == cfg.m) ? '0 : wy + ONE;
    assign fill_nx    = (fill == cfg.n) ? fill : fill + ONE;
    assign take       = (st == ST_WAIT) && in_valid;
    assign last       = (idx == len - ONE);
    assign in_ready   = (st == ST_WAIT);
    assign out_valid  = (st == ST_OUT);
    assign acc_clr    = take && (fill_nx == cfg.n);
    assign mac_en     = (st == ST_MAC);
    assign gain_q     = cfg.gain;
    assign c_addr     = idx;

    always_comb begin
        j = idx - cfg.n;
        if (idx < cfg.n) begin
            off    = (xn >= idx) ? xn - idx : xn + cfg.n - idx;
            d_addr = xbase + off;
        end else begin
            off    = (yn >= j) ? yn - j : yn + cfg.m - j;
            d_addr = ybase + off;
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = host_addr;
        mem_wdata = host_wdata;
        if (st == ST_IDLE) begin
            mem_we = host_we;
        end else if (take) begin
            mem_we    = 1'b1;
            mem_waddr = xbase + wx;
            mem_wdata = in_data;
        end else if (st == ST_OUT && out_ready && cfg.iir) begin
            mem_we    = 1'b1;
            mem_waddr = ybase + wy;
            mem_wdata = result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cfg     <= '0;
            start_q <= 1'b0;
            cfg_err <= 1'b0;
            wx      <= '0;
            xn      <= '0;
            wy      <= '0;
            yn      <= '0;
            fill    <= '0;
            idx     <= '0;
        end else begin
            start_q <= start;
            if (!start) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (start_rise) begin
                        if (cfg_fits(func, p_cnt, q_cnt, pre_cnt)) begin
                            cfg.iir  <= (func == FN_IIR);
                            cfg.n    <= p_cnt;
                            cfg.m    <= (func == FN_IIR) ? q_cnt : '0;
                            cfg.gain <= gain;
                            wx       <= (pre_cnt == p_cnt) ? '0 : pre_cnt;
                            xn       <= (pre_cnt == '0) ? p_cnt - ONE : pre_cnt - ONE;
                            fill     <= pre_cnt;
                            wy       <= '0;
                            yn       <= (func == FN_IIR) ? q_cnt - ONE : '0;
                            cfg_err  <= 1'b0;
                            st       <= ST_WAIT;
                        end else begin
                            cfg_err <= 1'b1;
                        end
                    end
                    ST_WAIT: if (in_valid) begin
                        wx   <= wx_nx;
                        xn   <= wx;
                        fill <= fill_nx;
                        if (fill_nx == cfg.n) begin
                            idx <= '0;
                            st  <= ST_MAC;
                        end
                    end
                    ST_MAC: begin
                        idx <= idx + ONE;
                        if (last) st <= ST_OUT;
                    end
                    ST_OUT: if (out_ready) begin
                        if (cfg.iir) begin
                            yn <= wy;
                            wy <= wy_nx;
                        end
                        st <= ST_WAIT;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_SUM_NEEDS_FULL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MAC) |-> (fill == cfg.n)); // R3
    AST_STOP_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!in_ready && !out_valid)); // R6
    AST_REFUSED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (st == ST_IDLE)); // R5
    AST_X_READ_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MAC && idx < cfg.n) |->
        ({1'b0, d_addr} >= {1'b0, xbase} && {1'b0, d_addr} < {1'b0, xbase} + {1'b0, cfg.n})); // R2
endmodule

// File: rtl/dfi_filter_engine.sv
module dfi_filter_engine
    import dfi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    func,
    input  logic [7:0]    tap_cnt,
    input  logic [7:0]    fb_cnt,
    input  logic [2:0]    gain,
    input  logic [7:0]    preload_cnt,
    input  logic          host_we,
    input  logic [7:0]    host_addr,
    input  logic [15:0]   host_wdata,
    input  logic          in_valid,
    input  logic [15:0]   in_data,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [15:0]   out_data,
    output logic          cfg_err
);
    logic          mem_we, acc_clr, mac_en;
    logic [AW-1:0] mem_waddr, c_addr, d_addr;
    logic [DW-1:0] mem_wdata, c_data, d_data, result;
    logic [GW-1:0] gain_q;

    dfi_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .func(func), .p_cnt(tap_cnt),
        .q_cnt(fb_cnt), .gain(gain), .pre_cnt(preload_cnt),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .result(result),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .c_addr(c_addr), .d_addr(d_addr), .acc_clr(acc_clr), .mac_en(mac_en),
        .gain_q(gain_q), .cfg_err(cfg_err)
    );

    dfi_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(c_addr), .rdata_a(c_data), .raddr_b(d_addr), .rdata_b(d_data)
    );

    dfi_mac u_mac (
        .clk(clk), .rst(rst), .clr(acc_clr), .en(mac_en), .coef(c_data),
        .data(d_data), .gain(gain_q), .result(result)
    );

    assign out_data = result;

    AST_OUT_HELD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && start) |=> (out_valid && $stable(out_data))); // R7
endmodule

// File: tb/tb_dfi_filter_engine.sv
module tb_dfi_filter_engine;
    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [3:0]  func = '0;
    logic [7:0]  tap_cnt = '0, fb_cnt = '0, preload_cnt = '0;
    logic [2:0]  gain = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, cfg_err;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    dfi_filter_engine dut (
        .clk(clk), .rst(rst), .start(start), .func(func), .tap_cnt(tap_cnt),
        .fb_cnt(fb_cnt), .gain(gain), .preload_cnt(preload_cnt),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cfg_err(cfg_err)
    );

    int    n_checks = 0, n_errs = 0;
    int    exp_q[$];
    string tag_q[$];
    int    b_m[256], a_m[256];
    int    xs[$], ys[$];
    int    m_n = 0, m_m = 0, m_g = 0, m_fill = 0;
    bit    m_iir = 0, bp_en = 0;
    logic [7:0] lf = 8'hA5;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_out();
        longint acc = 0;
        for (int k = 0; k < m_n; k++) acc += longint'(b_m[k]) * longint'(xs[xs.size()-1-k]);
        for (int k = 1; k <= m_m; k++) acc += longint'(a_m[k-1]) * longint'(ys[ys.size()-k]);
        acc = acc <<< m_g;
        acc = acc >>> 15;
        if (acc > 32767) return 32767;
        if (acc < -32768) return -32768;
        return int'(acc);
    endfunction

    task automatic host_wr(input int a, input int d);
        host_we = 1'b1; host_addr = 8'(a); host_wdata = 16'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic cfg_set(input int fn, input int p, input int q, input int g, input int pre);
        start = 1'b0;
        func = 4'(fn); tap_cnt = 8'(p); fb_cnt = 8'(q); gain = 3'(g); preload_cnt = 8'(pre);
        m_n = p; m_iir = (fn == 9); m_m = m_iir ? q : 0; m_g = g; m_fill = pre;
        xs.delete(); ys.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_b(input int k, input int v); host_wr(k, v); b_m[k] = v; endtask
    task automatic wr_a(input int k, input int v); host_wr(m_n + k - 1, v); a_m[k-1] = v; endtask
    task automatic wr_x(input int v); host_wr(m_n + m_m + xs.size(), v); xs.push_back(v); endtask
    task automatic wr_yz();
        for (int k = 0; k < m_m; k++) begin host_wr(2 * m_n + m_m + k, 0); ys.push_back(0); end
    endtask
    task automatic go(); start = 1'b1; repeat (2) @(negedge clk); endtask

    task automatic send(input int v, input bit keep, input string tag);
        in_valid = 1'b1; in_data = 16'(v);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        xs.push_back(v);
        if (m_fill < m_n) m_fill++;
        if (m_fill >= m_n && keep) begin
            int e;
            e = model_out();
            exp_q.push_back(e); tag_q.push_back(tag);
            if (m_iir) ys.push_back(e);
        end
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (exp_q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, "results outstanding", exp_q.size(), 0);
    endtask

    task automatic idle_check(input int cyc, input string tag);
        bit seen = 0;
        for (int i = 0; i < cyc; i++) begin @(negedge clk); if (out_valid) seen = 1; end
        check(!seen, tag, "out_valid seen", int'(seen), 0);
    endtask

    // Scoreboard monitor
    bit         hold_p = 0;
    logic [15:0] hold_d = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (hold_p) begin
                check(out_valid && out_data == hold_d, "R7", "held result changed",
                      int'($signed(out_data)), int'($signed(hold_d)));
                hold_p = 0;
            end
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = bp_en ? lf[0] : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected result", int'($signed(out_data)), 0);
                end else begin
                    int    e;
                    string tg;
                    e = exp_q.pop_front(); tg = tag_q.pop_front();
                    check(int'($signed(out_data)) == e, tg, "result", int'($signed(out_data)), e);
                end
            end else if (out_valid) begin
                hold_p = 1; hold_d = out_data;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL R6 watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!in_ready, "R6", "reset in_ready", int'(in_ready), 0);
        check(!out_valid, "R6", "reset out_valid", int'(out_valid), 0);
        check(!cfg_err, "R5", "reset cfg_err", int'(cfg_err), 0);

        // R1 FIR with a junk feedback count, R3 window fill, R8 writes while running
        cfg_set(8, 4, 77, 0, 0);
        wr_b(0, 16384); wr_b(1, -8192); wr_b(2, 4096); wr_b(3, 1000);
        go();
        send(1000, 1, "R3"); send(-2000, 1, "R3"); send(3000, 1, "R3");
        idle_check(12, "R3");
        send(4000, 1, "R1"); send(-5000, 1, "R1"); send(12000, 1, "R1");
        send(32767, 1, "R1"); send(-32768, 1, "R1");
        drain("R1");
        host_wr(0, 999);
        send(500, 1, "R8"); send(600, 1, "R8"); send(700, 1, "R8");
        drain("R8");

        // R4 saturation and gain
        cfg_set(8, 2, 0, 3, 0);
        wr_b(0, 32767); wr_b(1, 32767);
        go();
        send(32767, 1, "R4"); send(32767, 1, "R4"); send(-32768, 1, "R4");
        send(-32768, 1, "R4"); send(100, 1, "R4");
        drain("R4");
        cfg_set(8, 2, 0, 2, 0);
        wr_b(0, 16384); wr_b(1, 16384);
        go();
        send(256, 1, "R4"); send(512, 1, "R4"); send(-1000, 1, "R4");
        drain("R4");

        // R2 / R9 IIR with preload, under backpressure (R7)
        cfg_set(9, 3, 2, 1, 2);
        wr_b(0, 8192); wr_b(1, 4096); wr_b(2, 2048);
        wr_a(1, 16384); wr_a(2, -8192);
        wr_x(100); wr_x(200); wr_yz();
        bp_en = 1;
        go();
        send(300, 1, "R3");
        send(-400, 1, "R2"); send(5000, 1, "R9"); send(20000, 1, "R9");
        send(32767, 1, "R9"); send(-32768, 1, "R2"); send(0, 1, "R9");
        send(1234, 1, "R9"); send(-777, 1, "R2"); send(0, 1, "R9");
        drain("R9");
        bp_en = 0;

        // R5 refusals and boundaries
        cfg_set(9, 3, 0, 0, 0); go();
        check(cfg_err, "R5", "M=0 err", int'(cfg_err), 1);
        check(!in_ready, "R5", "M=0 ready", int'(in_ready), 0);
        cfg_set(9, 3, 3, 0, 0); go();
        check(cfg_err, "R5", "M=N err", int'(cfg_err), 1);
        cfg_set(9, 100, 40, 0, 0); go();
        check(cfg_err, "R5", "IIR budget err", int'(cfg_err), 1);
        cfg_set(8, 129, 0, 0, 0); go();
        check(cfg_err, "R5", "FIR budget err", int'(cfg_err), 1);
        cfg_set(5, 4, 1, 0, 0); go();
        check(cfg_err, "R5", "bad mode err", int'(cfg_err), 1);
        check(!in_ready, "R5", "bad mode ready", int'(in_ready), 0);
        cfg_set(8, 4, 0, 0, 5); go();
        check(cfg_err, "R5", "preload err", int'(cfg_err), 1);
        cfg_set(8, 0, 0, 0, 0); go();
        check(cfg_err, "R5", "N=0 err", int'(cfg_err), 1);
        cfg_set(9, 100, 20, 0, 0); go();
        check(!cfg_err, "R5", "IIR fits err", int'(cfg_err), 0);
        check(in_ready, "R5", "IIR fits ready", int'(in_ready), 1);
        cfg_set(8, 128, 0, 0, 0); go();
        check(!cfg_err && in_ready, "R5", "FIR 128 accepted", int'(cfg_err), 0);

        // R6 abort mid-sum and relaunch
        cfg_set(8, 2, 0, 0, 2);
        wr_b(0, 1000); wr_b(1, 2000); wr_x(7); wr_x(9);
        go();
        send(300, 0, "R6");
        start = 1'b0;
        @(negedge clk);
        check(!in_ready && !out_valid, "R6", "stop outputs", int'(in_ready | out_valid), 0);
        idle_check(10, "R6");
        cfg_set(8, 2, 0, 0, 2);
        wr_x(7); wr_x(9);
        go();
        send(300, 1, "R6"); send(-300, 1, "R6");
        drain("R6");

        start = 1'b0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule